// File: doc/BRIEF.md
# SPI Command Engine with Shared Byte Queue

This block is a host-side SPI master reached through a small byte-wide register window. Software programs a command byte and a packed pair of byte counts, then loads outgoing payload bytes into an eight-entry queue through a single data port. A write that sets the start bit launches one framed transfer: chip select falls, the command byte goes out first, the payload bytes follow, and then the engine clocks in the requested number of reply bytes.

The queue is shared between directions. Payload bytes occupy the first entries and the captured reply lands in the entries just after them, so software rewinds the queue pointer, steps past the payload entries, and reads the reply through the same data port. The pointer is three bits wide, readable, wraps modulo eight, and is rewound by a control bit. The serial clock comes from the system clock, with its half period picked by a two-bit speed field.

Top module: `spi_cmd_engine`

## Requirements
- R1: The command byte is written and read back at offset 0x0; it is always the first byte shifted out in a transfer and is never taken from the queue.
- R2: Offset 0x1 holds the reply count in bits [7:4] and the payload count in bits [3:0]; its read value stays equal to the programmed value through a transfer and the readout that follows.
- R3: Writing offset 0x2 with bit 0 set starts a transfer; bit 0 of offset 0x2 reads 1 from the cycle after that write until chip select returns high, and reads 0 afterwards.
- R4: Writing offset 0x2 with bit 4 set forces the queue pointer to 0.
- R5: A write or read of the data port at offset 0xC touches the queue entry at the pointer, after which the pointer increments modulo 8.
- R6: Offset 0xD reads the pointer in bits [2:0] and the speed field in bits [5:4]; after reset the speed field is 2'b11 and the pointer is 0.
- R7: The serial clock stays high for 2, 3 or 4 system clock cycles for speed 2'b01, 2'b10 or 2'b11; the reserved code 2'b00 behaves like 2'b11.
- R8: A transfer with payload count W and reply count R shifts out, MSB first in SPI mode 0, the command byte, then queue entries 0..W-1, then R bytes of 0x00, while reply byte j is stored into entry (W+j) mod 8.
- R9: After a transfer, a pointer rewind and a readout of W+R data-port reads, the pointer equals (W+R) mod 8.
- R10: While a transfer runs, every register write is ignored and data-port reads do not move the pointer.
- R11: After reset chip select is high, the serial clock is low, offset 0x2 reads 0 and offsets 0x0 and 0x1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench aims at the seams of the shared queue: a transfer with no payload, where replies must start at entry 0, one whose payload and reply together fill all eight entries, and a nine-byte load that wraps the pointer; an engine that stored replies from entry 0 or misplaced the boundary would return payload bytes where replies belong. It also fires register writes and data-port reads in the middle of a transfer; a design that let them through would corrupt the counts, the command byte or the pointer seen afterwards. Every speed code, including the reserved one, is timed by the width of the serial clock high phase, which catches a wrong divider choice.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 4;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int POS_W   = CNT_W + 1;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNTS = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_CFG    = 4'hD;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_REWIND_BIT = 4;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_XFER
    } seq_state_e;

    typedef struct packed {
        seq_state_e              state;
        logic                    cs_n;
        logic                    sck;
        logic [BYTE_W-1:0]       sh;
        logic [BYTE_W-1:0]       rx;
        logic [BIT_W-1:0]        bitn;
        logic [POS_W-1:0]        pos;
    } seq_regs_t;

endpackage

// File: rtl/spi_cmd_clkdiv.sv
`timescale 1ns/1ps
module spi_cmd_clkdiv #(
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 3,
    parameter int HALF_SLOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] speed,
    output logic       tick
);
    localparam int CW = $clog2(HALF_SLOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        case (speed)
            2'b01:   limit = CW'(HALF_FAST - 1);
            2'b10:   limit = CW'(HALF_MID - 1);
            default: limit = CW'(HALF_SLOW - 1);
        endcase
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic                     busy,
    input  logic                     eng_we,
    input  logic [$clog2(DEPTH)-1:0] eng_widx,
    input  logic [BYTE_W-1:0]        eng_wdata,
    input  logic [$clog2(DEPTH)-1:0] eng_ridx,
    output logic [BYTE_W-1:0]        eng_rdata,
    output logic [BYTE_W-1:0]        opcode,
    output logic [CNT_W-1:0]         wcnt,
    output logic [CNT_W-1:0]         rcnt,
    output logic [1:0]               speed,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output logic                     go
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [BYTE_W-1:0]             opcode;
        logic [2*CNT_W-1:0]            counts;
        logic [1:0]                    speed;
        logic [PW-1:0]                 ptr;
        logic [DEPTH-1:0][BYTE_W-1:0]  fifo;
    } regs_t;

    regs_t r_d, r_q;
    logic  open_win;

    always_comb begin
        r_d      = r_q;
        go       = 1'b0;
        open_win = !busy;
        if (bus_wr && open_win) begin
            case (bus_addr)
                OFS_OPCODE: r_d.opcode = bus_wdata;
                OFS_COUNTS: r_d.counts = bus_wdata;
                OFS_CTRL: begin
                    if (bus_wdata[CTRL_REWIND_BIT]) r_d.ptr = '0;
                    go = bus_wdata[CTRL_GO_BIT];
                end
                OFS_DATA: begin
                    r_d.fifo[r_q.ptr] = bus_wdata;
                    r_d.ptr           = r_q.ptr + 1'b1;
                end
                OFS_CFG: r_d.speed = bus_wdata[5:4];
                default: ;
            endcase
        end
        if (bus_rd && open_win && bus_addr == OFS_DATA) begin
            r_d.ptr = r_q.ptr + 1'b1;
        end
        if (eng_we) begin
            r_d.fifo[eng_widx] = eng_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_OPCODE: bus_rdata = r_q.opcode;
            OFS_COUNTS: bus_rdata = r_q.counts;
            OFS_CTRL:   bus_rdata = {7'b0, busy};
            OFS_DATA:   bus_rdata = r_q.fifo[r_q.ptr];
            OFS_CFG:    bus_rdata = BYTE_W'({r_q.speed, 4'b0000}) | BYTE_W'(r_q.ptr);
            default:    bus_rdata = '0;
        endcase
        eng_rdata = r_q.fifo[eng_ridx];
        opcode    = r_q.opcode;
        rcnt      = r_q.counts[2*CNT_W-1:CNT_W];
        wcnt      = r_q.counts[CNT_W-1:0];
        speed     = r_q.speed;
        ptr       = r_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.speed  <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic                     tick,
    input  logic [BYTE_W-1:0]        opcode,
    input  logic [CNT_W-1:0]         wcnt,
    input  logic [CNT_W-1:0]         rcnt,
    input  logic                     miso,
    input  logic [BYTE_W-1:0]        eng_rdata,
    output logic [$clog2(DEPTH)-1:0] eng_ridx,
    output logic                     eng_we,
    output logic [$clog2(DEPTH)-1:0] eng_widx,
    output logic [BYTE_W-1:0]        eng_wdata,
    output logic                     busy,
    output logic                     cs_n,
    output logic                     sck,
    output logic                     mosi
);
    localparam int PW = $clog2(DEPTH);

    seq_regs_t s_d, s_q;
    logic [POS_W-1:0] last_pos;
    logic [POS_W-1:0] wlen;
    logic [POS_W-1:0] next_pos;

    always_comb begin
        s_d       = s_q;
        eng_we    = 1'b0;
        wlen      = {1'b0, wcnt};
        last_pos  = {1'b0, wcnt} + {1'b0, rcnt};
        next_pos  = s_q.pos + 1'b1;
        // byte at position p (p >= 1) lives in entry (p-1) mod DEPTH
        eng_ridx  = s_q.pos[PW-1:0];
        eng_widx  = s_q.pos[PW-1:0] - 1'b1;
        eng_wdata = s_q.rx;
        case (s_q.state)
            SEQ_IDLE: begin
                if (go) begin
                    s_d.state = SEQ_XFER;
                    s_d.cs_n  = 1'b0;
                    s_d.sck   = 1'b0;
                    s_d.sh    = opcode;
                    s_d.rx    = '0;
                    s_d.bitn  = '0;
                    s_d.pos   = '0;
                end
            end
            SEQ_XFER: begin
                if (tick) begin
                    if (!s_q.sck) begin
                        s_d.sck = 1'b1;
                        s_d.rx  = {s_q.rx[BYTE_W-2:0], miso};
                    end else begin
                        s_d.sck = 1'b0;
                        if (s_q.bitn == BIT_W'(BYTE_W - 1)) begin
                            eng_we = (s_q.pos > wlen);
                            if (s_q.pos == last_pos) begin
                                s_d.state = SEQ_IDLE;
                                s_d.cs_n  = 1'b1;
                            end else begin
                                s_d.pos  = next_pos;
                                s_d.bitn = '0;
                                s_d.sh   = (next_pos <= wlen) ? eng_rdata : '0;
                            end
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                            s_d.sh   = {s_q.sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
        busy = (s_q.state == SEQ_XFER);
        cs_n = s_q.cs_n;
        sck  = s_q.sck;
        mosi = s_q.sh[BYTE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= SEQ_IDLE;
            s_q.cs_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 3,
    parameter int HALF_SLOW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int PW = $clog2(DEPTH);

    logic              seq_busy;
    logic              go;
    logic              tick;
    logic [7:0]        opcode;
    logic [CNT_W-1:0]  wcnt, rcnt;
    logic [1:0]        speed;
    logic [PW-1:0]     fifo_ptr;
    logic              eng_we;
    logic [PW-1:0]     eng_widx, eng_ridx;
    logic [7:0]        eng_wdata, eng_rdata;
    logic [2*CNT_W-1:0] cnt_reg;

    assign cnt_reg = {rcnt, wcnt};

    spi_cmd_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(seq_busy),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .eng_ridx(eng_ridx), .eng_rdata(eng_rdata),
        .opcode(opcode), .wcnt(wcnt), .rcnt(rcnt), .speed(speed),
        .ptr(fifo_ptr), .go(go)
    );

    spi_cmd_clkdiv #(
        .HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run(seq_busy), .speed(speed), .tick(tick)
    );

    spi_cmd_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
        .opcode(opcode), .wcnt(wcnt), .rcnt(rcnt), .miso(spi_miso),
        .eng_rdata(eng_rdata), .eng_ridx(eng_ridx),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .busy(seq_busy), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    bus_addr,
    input logic          bus_wr,
    input logic          busy,
    input logic [PW-1:0] ptr,
    input logic [7:0]    cnt,
    input logic          spi_cs_n,
    input logic          spi_sck,
    input logic          spi_mosi
);
    // R3: a running transfer always holds chip select low
    a_r3_busy_holds_select: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !spi_cs_n);

    // R11: serial clock rests low whenever chip select is high
    a_r11_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8: data out only moves while the serial clock is low (mode 0)
    a_r8_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R10: the pointer cannot move on an access made during a transfer
    a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(ptr));

    // R2: count register holds during a transfer
    a_r2_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(cnt));

    // R5: an accepted data-port write advances the pointer by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 4'hC && !busy) |-> (ptr == PW'($past(ptr) + 1'b1)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .busy(seq_busy), .ptr(fifo_ptr), .cnt(cnt_reg),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- serial device model ----------------
    logic [7:0] seed = 8'h00;
    logic [7:0] s_out, s_in;
    int         s_bit, s_byte;
    logic [7:0] rx_log [32];

    function automatic logic [7:0] resp(input logic [7:0] sd, input int k);
        return sd ^ 8'(k * 59);
    endfunction

    function automatic logic [7:0] txb(input logic [7:0] op, input int i);
        return ~op + 8'(i * 23);
    endfunction

    always @(negedge spi_cs_n) begin
        s_bit = 0; s_byte = 0;
        s_out = resp(seed, 0);
        spi_miso = s_out[7];
    end
    always @(posedge spi_sck) s_in = {s_in[6:0], spi_mosi};
    always @(negedge spi_sck) begin
        s_bit = s_bit + 1;
        if (s_bit == 8) begin
            if (s_byte < 32) rx_log[s_byte] = s_in;
            s_byte = s_byte + 1;
            s_bit = 0;
            s_out = resp(seed, s_byte);
        end else begin
            s_out = {s_out[6:0], 1'b0};
        end
        spi_miso = s_out[7];
    end

    // serial clock high-phase width, in system cycles
    int hi_cnt = 0;
    int last_hi = 0;
    always @(posedge clk) begin
        if (spi_sck) hi_cnt = hi_cnt + 1;
        else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output int ok);
        logic [7:0] v;
        ok = 0;
        for (int n = 0; n < 3000; n++) begin
            br(4'h2, v);
            if (v[0] == 1'b0) begin ok = 1; break; end
        end
    endtask

    // opcode, counts {R,W}, speed code, reply seed
    localparam logic [31:0] VEC [6] = '{
        {8'h9F, 8'h30, 8'h01, 8'h5A},
        {8'h03, 8'h44, 8'h02, 8'hC3},
        {8'h02, 8'h05, 8'h03, 8'h11},
        {8'h05, 8'h10, 8'h00, 8'h7E},
        {8'h0B, 8'h71, 8'h01, 8'hE4},
        {8'hAB, 8'h00, 8'h02, 8'h33}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R6: reset state
        chk("R11", "cs_n after reset", spi_cs_n, 1);
        chk("R11", "sck after reset", spi_sck, 0);
        br(4'h2, v); chk("R11", "ctrl after reset", v, 8'h00);
        br(4'h0, v); chk("R11", "opcode after reset", v, 8'h00);
        br(4'h1, v); chk("R11", "counts after reset", v, 8'h00);
        br(4'hD, v); chk("R6", "cfg after reset", v, 8'h30);

        foreach (VEC[t]) begin
            logic [7:0] op, cn, sp;
            int w, r, half;
            op = VEC[t][31:24]; cn = VEC[t][23:16]; sp = VEC[t][15:8];
            seed = VEC[t][7:0];
            w = cn[3:0]; r = cn[7:4];
            half = (sp[1:0] == 2'b01) ? 2 : (sp[1:0] == 2'b10) ? 3 : 4;
            bw(4'hD, {2'b00, sp[1:0], 4'h0});
            br(4'hD, v); chk("R6", "speed readback", v[5:4], sp[1:0]);
            bw(4'h0, op);
            bw(4'h1, cn);
            bw(4'h2, 8'h10);
            br(4'hD, v); chk("R4", "ptr after rewind", v[2:0], 0);
            for (int i = 0; i < w; i++) bw(4'hC, txb(op, i));
            br(4'hD, v); chk("R5", "ptr after payload load", v[2:0], w % 8);
            bw(4'h2, 8'h10);
            bw(4'h2, 8'h01);
            br(4'h2, v); chk("R3", "busy while running", v[0], 1);
            chk("R3", "cs low while running", spi_cs_n, 0);
            wait_idle(ok);
            chk("R3", "transfer finished", ok, 1);
            chk("R3", "cs high after finish", spi_cs_n, 1);
            chk("R7", "sck high width", last_hi, half);
            chk("R1", "first byte is opcode", rx_log[0], op);
            for (int i = 0; i < w; i++)
                chk("R8", "payload byte on wire", rx_log[1 + i], txb(op, i));
            if (r > 0) chk("R8", "zero during reply", rx_log[1 + w], 8'h00);
            br(4'h1, v); chk("R2", "counts after transfer", v, cn);
            bw(4'h2, 8'h10);
            for (int i = 0; i < w; i++) begin
                br(4'hC, v); chk("R8", "payload kept in queue", v, txb(op, i));
            end
            for (int j = 0; j < r; j++) begin
                br(4'hC, v); chk("R8", "reply in queue", v, resp(seed, w + 1 + j));
            end
            br(4'hD, v); chk("R9", "ptr after readout", v[2:0], (w + r) % 8);
            br(4'h1, v); chk("R2", "counts after readout", v, cn);
        end

        // R5: pointer wraps and overwrites entry 0
        bw(4'h2, 8'h10);
        for (int i = 0; i < 9; i++) bw(4'hC, 8'h40 + 8'(i));
        br(4'hD, v); chk("R5", "ptr wraps after 9 writes", v[2:0], 1);
        bw(4'h2, 8'h10);
        br(4'hC, v); chk("R5", "entry 0 overwritten", v, 8'h48);
        br(4'hC, v); chk("R5", "entry 1 kept", v, 8'h41);

        // R10: accesses during a transfer are ignored
        seed = 8'h21;
        bw(4'hD, 8'h30);
        bw(4'h0, 8'h6B);
        bw(4'h1, 8'h22);
        bw(4'h2, 8'h10);
        bw(4'h2, 8'h01);
        bw(4'h0, 8'hEE);
        bw(4'h1, 8'hFF);
        bw(4'hC, 8'h99);
        bw(4'hD, 8'h10);
        br(4'hC, v);
        bw(4'h2, 8'h10);
        br(4'h2, v); chk("R10", "still busy during probes", v[0], 1);
        wait_idle(ok);
        chk("R10", "probe transfer finished", ok, 1);
        br(4'h0, v); chk("R10", "opcode unchanged", v, 8'h6B);
        br(4'h1, v); chk("R10", "counts unchanged", v, 8'h22);
        br(4'hD, v); chk("R10", "ptr and speed unchanged", v, 8'h30);
        chk("R10", "opcode on wire", rx_log[0], 8'h6B);
        br(4'hC, v); chk("R10", "entry 0 unchanged", v, 8'h48);
        br(4'hC, v); chk("R10", "entry 1 unchanged", v, 8'h41);
        br(4'hC, v); chk("R8", "reply entry 2", v, resp(8'h21, 3));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule